// File: doc/BRIEF.md
# Integer Arithmetic Unit with Status Flags

This block performs two-operand integer arithmetic at a selectable width of 8, 16 or 32 bits and produces the six arithmetic status flags that conditional logic downstream relies on. It supports plain addition, addition with incoming carry, plain subtraction, subtraction with incoming borrow, compare, increment and decrement. The carry-in and borrow-in forms let a sequencer build wider arithmetic by feeding the carry flag from the low-word operation into the high-word operation.

Each operation is presented with a one-cycle valid strobe together with the current flag word. On the next clock edge the unit registers the width-limited result, a one-cycle destination write enable, and the updated flag word. Flag updates depend on the operation. Compare computes the difference but never asserts the write enable. Increment and decrement keep the old carry. After any subtraction the carry and auxiliary carry hold borrows. Bits of the flag word outside the arithmetic six are copied through unchanged.

Top module: `arith_flag_unit`

## Requirements
- R1: Opcode 0 (add) registers (A+B) at the selected width; opcode 1 (add with carry) registers A+B+C, where C is bit 0 of the incoming flag word; flag bit 0 (carry) is set when the unsigned sum exceeds the width's maximum.
- R2: Opcode 2 (subtract) registers A-B and opcode 3 (subtract with borrow) registers A-B-C; after either, flag bit 0 holds the borrow (set when the unsigned minuend is smaller than subtrahend plus borrow-in).
- R3: Flag bit 5 (overflow) is set when the exact signed result lies outside the signed range of the selected width (byte 22h minus 44h gives DEh with overflow clear and carry set).
- R4: Flag bit 1 (auxiliary carry) holds the carry, or after subtraction the borrow, from bit 3 into bit 4, at every width.
- R5: Size code 0 selects 8 bits, 1 selects 16, 2 or 3 select 32. Operand bits above the width are ignored and result bits above it are zero. Flag bit 4 (sign) is the result's top bit at that width, and flag bit 3 (zero) is set when the width-limited result is zero.
- R6: Flag bit 2 (parity) is set when the low byte of the result has an even number of one bits.
- R7: Opcode 5 (increment) adds 1 to A and opcode 6 (decrement) subtracts 1, ignoring B; both update flag bits 1 to 5 and keep flag bit 0 at its incoming value.
- R8: Opcode 4 (compare) sets flag bits 0 to 5 exactly as subtract would, but the write enable stays low.
- R9: Flag word bits 6 to 15 pass from the incoming flag word to the registered flag word unchanged for every opcode.
- R10: Result, write enable and flag word are registered on the edge where the valid strobe is high. The write enable is high only in the cycle after a valid non-compare arithmetic operation. Without valid, flags and result hold.
- R11: Synchronous reset clears the flag word, the result and the write enable.
- R12: Opcode 7 is reserved: the write enable stays low and the registered flag word equals the incoming flag word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_i | input | 3 | Opcode |
| size_i | input | 2 | Width select |
| opa_i | input | 32 | Operand A (destination value) |
| opb_i | input | 32 | Operand B (source value) |
| flags_i | input | 16 | Current flag word |
| result_o | output | 32 | Registered width-limited result |
| wr_en_o | output | 1 | Destination write enable, one cycle |
| flags_o | output | 16 | Registered next flag word |

## Verification
The in-RTL assertions watch, on every cycle, the properties that only need the ports: compare and reserved opcodes never raise the write enable, and increment and decrement keep the carry. They also check that control bits pass through, that the zero and parity flags agree with a written result, that upper result bits clear at byte width, and that state holds without a strobe. The exact sums, borrows, auxiliary carries and signed overflow at each width need expected values. The bench's directed scenarios provide them, including the 0FFh+1 wrap, 7Fh+1 and 80h-1 overflow, a 64-bit chain built from two 32-bit operations, and the byte subtraction 22h-44h.

// File: rtl/afu_pkg.sv
`timescale 1ns/1ps
package afu_pkg;
    localparam int DATA_W    = 32;
    localparam int FLAG_W    = 16;
    localparam int NUM_SIZES = 3;
    localparam int ARITH_N   = 6;

    localparam int F_C = 0;
    localparam int F_A = 1;
    localparam int F_P = 2;
    localparam int F_Z = 3;
    localparam int F_S = 4;
    localparam int F_V = 5;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_CMP = 3'd4,
        OP_INC = 3'd5,
        OP_DEC = 3'd6,
        OP_RSV = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_ALT  = 2'd3
    } size_e;

    // packed so that c lands in bit 0 and v in bit 5
    typedef struct packed {
        logic v;
        logic s;
        logic z;
        logic p;
        logic a;
        logic c;
    } aflags_t;

    typedef struct packed {
        logic sub;      // subtract path
        logic use_cin;  // fold incoming carry/borrow
        logic one_b;    // replace B with constant 1
        logic keep_c;   // carry flag keeps its old value
        logic write;    // destination write
        logic update;   // arithmetic flags change
    } ctl_t;

    function automatic ctl_t decode_op(input op_e op);
        ctl_t d;
        d = '0;
        case (op)
            OP_ADD: begin d.write = 1'b1; d.update = 1'b1; end
            OP_ADC: begin d.use_cin = 1'b1; d.write = 1'b1; d.update = 1'b1; end
            OP_SUB: begin d.sub = 1'b1; d.write = 1'b1; d.update = 1'b1; end
            OP_SBB: begin d.sub = 1'b1; d.use_cin = 1'b1; d.write = 1'b1; d.update = 1'b1; end
            OP_CMP: begin d.sub = 1'b1; d.update = 1'b1; end
            OP_INC: begin d.one_b = 1'b1; d.keep_c = 1'b1; d.write = 1'b1; d.update = 1'b1; end
            OP_DEC: begin d.sub = 1'b1; d.one_b = 1'b1; d.keep_c = 1'b1; d.write = 1'b1; d.update = 1'b1; end
            default: d = '0;
        endcase
        return d;
    endfunction

    function automatic logic [1:0] size_index(input size_e sz);
        case (sz)
            SZ_BYTE: return 2'd0;
            SZ_HALF: return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] width_mask(input size_e sz);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_SIZES; i++) begin
            if (size_index(sz) == 2'(i))
                m = DATA_W'((64'd1 << (8 << i)) - 64'd1);
        end
        return m;
    endfunction
endpackage

// File: rtl/afu_operands.sv
`timescale 1ns/1ps
module afu_operands
    import afu_pkg::*;
(
    input  size_e             size_i,
    input  logic              one_b_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] ma_o,
    output logic [DATA_W-1:0] mb_o
);
    always_comb begin
        mask_o = width_mask(size_i);
        ma_o   = a_i & mask_o;
        mb_o   = one_b_i ? DATA_W'(1) : (b_i & mask_o);
    end
endmodule

// File: rtl/afu_adder.sv
`timescale 1ns/1ps
module afu_adder
    import afu_pkg::*;
(
    input  logic              sub_i,
    input  logic              cin_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W:0]   ext_o
);
    localparam int EXT_W = DATA_W + 1;
    logic [EXT_W-1:0] xa, xb, xc;

    always_comb begin
        xa = {1'b0, a_i};
        xb = {1'b0, b_i};
        xc = EXT_W'(cin_i);
        // operands are width-masked, so bit W of the extended value is the
        // carry out on add and the borrow out on subtract
        ext_o = sub_i ? (xa - xb - xc) : (xa + xb + xc);
    end
endmodule

// File: rtl/afu_flags.sv
`timescale 1ns/1ps
module afu_flags
    import afu_pkg::*;
(
    input  size_e             size_i,
    input  logic              sub_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic [DATA_W-1:0] ma_i,
    input  logic [DATA_W-1:0] mb_i,
    input  logic [DATA_W:0]   ext_i,
    output logic [DATA_W-1:0] res_o,
    output aflags_t           fl_o
);
    logic [NUM_SIZES-1:0] cy, sg, ov;
    logic [1:0]           sel;

    for (genvar gi = 0; gi < NUM_SIZES; gi++) begin : g_width
        localparam int W = 8 << gi;
        logic sa, sb;
        always_comb begin
            sa     = ma_i[W-1];
            sb     = mb_i[W-1];
            cy[gi] = ext_i[W];
            sg[gi] = ext_i[W-1];
            ov[gi] = sub_i ? ((sa != sb) && (sg[gi] != sa))
                           : ((sa == sb) && (sg[gi] != sa));
        end
    end

    always_comb begin
        sel     = size_index(size_i);
        res_o   = ext_i[DATA_W-1:0] & mask_i;
        fl_o.c  = cy[sel];
        fl_o.a  = ma_i[4] ^ mb_i[4] ^ ext_i[4];
        fl_o.p  = ~^res_o[7:0];
        fl_o.z  = (res_o == '0);
        fl_o.s  = sg[sel];
        fl_o.v  = ov[sel];
    end
endmodule

// File: rtl/arith_flag_unit.sv
`timescale 1ns/1ps
module arith_flag_unit
    import afu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        op_i,
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic [FLAG_W-1:0] flags_o
);
    ctl_t              ctl;
    size_e             sz;
    logic              cin;
    logic [DATA_W-1:0] mask, ma, mb, res;
    logic [DATA_W:0]   ext;
    aflags_t           fl;
    logic [FLAG_W-1:0] nflags;

    always_comb begin
        ctl = decode_op(op_e'(op_i));
        sz  = size_e'(size_i);
        cin = ctl.use_cin & flags_i[F_C];
    end

    afu_operands u_opr (
        .size_i (sz),
        .one_b_i(ctl.one_b),
        .a_i    (opa_i),
        .b_i    (opb_i),
        .mask_o (mask),
        .ma_o   (ma),
        .mb_o   (mb)
    );

    afu_adder u_add (
        .sub_i(ctl.sub),
        .cin_i(cin),
        .a_i  (ma),
        .b_i  (mb),
        .ext_o(ext)
    );

    afu_flags u_flg (
        .size_i(sz),
        .sub_i (ctl.sub),
        .mask_i(mask),
        .ma_i  (ma),
        .mb_i  (mb),
        .ext_i (ext),
        .res_o (res),
        .fl_o  (fl)
    );

    always_comb begin
        nflags = flags_i;
        if (ctl.update) begin
            nflags[ARITH_N-1:0] = fl;
            if (ctl.keep_c)
                nflags[F_C] = flags_i[F_C];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_o  <= '0;
            result_o <= '0;
            wr_en_o  <= 1'b0;
        end else if (in_valid) begin
            flags_o  <= nflags;
            result_o <= res;
            wr_en_o  <= ctl.write;
        end else begin
            wr_en_o  <= 1'b0;
        end
    end

    // R8: compare never writes the destination
    p_cmp_nowrite_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_i == 3'd4) |=> !wr_en_o);

    // R12: reserved opcode writes nothing and leaves the flag word as given
    p_rsv_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_i == 3'd7) |=> (!wr_en_o && flags_o == $past(flags_i)));

    // R7: increment and decrement keep the carry
    p_incdec_carry_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op_i == 3'd5 || op_i == 3'd6)) |=> (flags_o[F_C] == $past(flags_i[F_C])));

    // R9: control bits copied through
    p_ctl_pass_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (flags_o[FLAG_W-1:ARITH_N] == $past(flags_i[FLAG_W-1:ARITH_N])));

    // R5: byte results carry no upper bits
    p_byte_upper_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size_i == 2'd0) |=> (result_o[DATA_W-1:8] == '0));

    // R5: zero flag agrees with a written result
    p_zero_match_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (flags_o[F_Z] == (result_o == '0)));

    // R6: parity agrees with a written result
    p_parity_match_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (flags_o[F_P] == ~^result_o[7:0]));

    // R10: without a strobe nothing changes and nothing is written
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(flags_o) && $stable(result_o) && !wr_en_o));
endmodule

// File: tb/sim_arith_flag_unit.sv
`timescale 1ns/1ps
module sim_arith_flag_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  op_i = '0;
    logic [1:0]  size_i = '0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [15:0] flags_i = '0;
    logic [31:0] result_o;
    logic        wr_en_o;
    logic [15:0] flags_o;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_res;
    logic        exp_wr;
    logic [15:0] exp_flags;

    always #2.5 clk = ~clk;

    arith_flag_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_i(op_i), .size_i(size_i),
        .opa_i(opa_i), .opb_i(opb_i), .flags_i(flags_i),
        .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
    );

    task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // expected values from the requirement text
    task automatic model(input [2:0] op, input [1:0] sz, input [31:0] a, input [31:0] b, input [15:0] fi);
        int w;
        longint m, ua, ub, c, full, res, sa, sb, sr, half;
        bit sub, upd, keepc;
        logic [7:0] lb;
        w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        m = (longint'(1) << w) - 1;
        half = (m + 1) / 2;
        ua = longint'(a) & m;
        ub = longint'(b) & m;
        sub = (op == 3'd2 || op == 3'd3 || op == 3'd4 || op == 3'd6);
        upd = (op != 3'd7);
        keepc = (op == 3'd5 || op == 3'd6);
        c = (op == 3'd1 || op == 3'd3) ? longint'(fi[0]) : 0;
        if (op == 3'd5 || op == 3'd6) ub = 1;
        full = sub ? (ua - ub - c) : (ua + ub + c);
        res = full & m;
        sa = (ua >= half) ? ua - (m + 1) : ua;
        sb = (ub >= half) ? ub - (m + 1) : ub;
        sr = sub ? (sa - sb - c) : (sa + sb + c);
        exp_res = 32'(res);
        exp_wr = !(op == 3'd4 || op == 3'd7);
        exp_flags = fi;
        lb = 8'(res);
        if (upd) begin
            exp_flags[0] = sub ? (full < 0) : (full > m);
            exp_flags[1] = sub ? ((ua & 15) < (ub & 15) + c) : ((ua & 15) + (ub & 15) + c > 15);
            exp_flags[2] = ($countones(lb) % 2) == 0;
            exp_flags[3] = (res == 0);
            exp_flags[4] = ((res >> (w - 1)) & 1) != 0;
            exp_flags[5] = (sr > half - 1) || (sr < -half);
            if (keepc) exp_flags[0] = fi[0];
        end
    endtask

    task automatic apply(input [2:0] op, input [1:0] sz, input [31:0] a, input [31:0] b, input [15:0] fi);
        @(negedge clk);
        op_i = op; size_i = sz; opa_i = a; opb_i = b; flags_i = fi; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        model(op, sz, a, b, fi);
    endtask

    task automatic check_all(input string tag, input bit chk_res);
        if (chk_res) check(tag, "result", result_o, exp_res);
        check(tag, "wr_en", 32'(wr_en_o), 32'(exp_wr));
        check(tag, "flags", 32'(flags_o), 32'(exp_flags));
    endtask

    task automatic t_reset();
        check("R11", "result", result_o, 32'h0);
        check("R11", "wr_en", 32'(wr_en_o), 32'h0);
        check("R11", "flags", 32'(flags_o), 32'h0);
    endtask

    task automatic t_add();
        apply(3'd0, 2'd0, 32'h12, 32'h33, 16'h0);
        check_all("R1", 1);
        check("R1", "byte sum", result_o, 32'h45);
        apply(3'd0, 2'd0, 32'hFF, 32'h01, 16'h0);
        check_all("R1", 1);
        check("R1", "carry", 32'(flags_o[0]), 32'h1);
        check("R4", "aux", 32'(flags_o[1]), 32'h1);
        apply(3'd0, 2'd1, 32'h7FFF, 32'h0001, 16'h0);
        check_all("R3", 1);
        check("R3", "ovf", 32'(flags_o[5]), 32'h1);
        apply(3'd0, 2'd2, 32'h8000_0000, 32'h8000_0000, 16'h0);
        check_all("R3", 1);
    endtask

    task automatic t_adc_chain();
        // 64-bit add 0x00000001_FFFFFFFF + 0x00000002_00000001 via two ops
        apply(3'd0, 2'd2, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0);
        check_all("R1", 1);
        apply(3'd1, 2'd2, 32'h1, 32'h2, flags_o);
        check_all("R1", 1);
        check("R1", "high word", result_o, 32'h4);
    endtask

    task automatic t_sub();
        apply(3'd2, 2'd0, 32'h22, 32'h44, 16'h0);
        check_all("R3", 1);
        check("R3", "22-44 result", result_o, 32'hDE);
        check("R3", "22-44 ovf", 32'(flags_o[5]), 32'h0);
        check("R2", "22-44 borrow", 32'(flags_o[0]), 32'h1);
        apply(3'd2, 2'd1, 32'h1000, 32'h0001, 16'h0);
        check_all("R4", 1);
        check("R4", "aux borrow", 32'(flags_o[1]), 32'h1);
        apply(3'd2, 2'd0, 32'h80, 32'h01, 16'h0);
        check_all("R3", 1);
    endtask

    task automatic t_sbb_chain();
        // 64-bit 0x00000005_00000000 - 0x00000001_00000001
        apply(3'd2, 2'd2, 32'h0, 32'h1, 16'h0);
        check_all("R2", 1);
        apply(3'd3, 2'd2, 32'h5, 32'h1, flags_o);
        check_all("R2", 1);
        check("R2", "high word", result_o, 32'h3);
    endtask

    task automatic t_cmp();
        apply(3'd0, 2'd2, 32'h5, 32'h6, 16'h0);
        apply(3'd4, 2'd0, 32'h10, 32'h10, 16'h0);
        check_all("R8", 0);
        check("R8", "no write", 32'(wr_en_o), 32'h0);
        apply(3'd4, 2'd0, 32'h0F, 32'h10, 16'h0);
        check_all("R8", 0);
    endtask

    task automatic t_incdec();
        apply(3'd5, 2'd0, 32'h7F, 32'hAB, 16'h0001);
        check_all("R7", 1);
        check("R7", "carry kept", 32'(flags_o[0]), 32'h1);
        apply(3'd5, 2'd0, 32'hFF, 32'h0, 16'h0000);
        check_all("R7", 1);
        apply(3'd6, 2'd1, 32'h0, 32'h55, 16'h0000);
        check_all("R7", 1);
        check("R7", "dec wrap", result_o, 32'hFFFF);
        apply(3'd6, 2'd0, 32'h80, 32'h0, 16'h0001);
        check_all("R7", 1);
    endtask

    task automatic t_size();
        apply(3'd0, 2'd0, 32'h1234_5680, 32'hABCD_EF01, 16'h0);
        check_all("R5", 1);
        check("R5", "upper zero", result_o, 32'h81);
        apply(3'd0, 2'd3, 32'h8000_0000, 32'h0, 16'h0);
        check_all("R5", 1);
        check("R5", "sign", 32'(flags_o[4]), 32'h1);
        apply(3'd2, 2'd1, 32'hFFFF_0003, 32'h0000_0003, 16'h0);
        check_all("R5", 1);
        check("R6", "parity of zero", 32'(flags_o[2]), 32'h1);
        apply(3'd0, 2'd0, 32'h01, 32'h00, 16'h0);
        check("R6", "odd parity", 32'(flags_o[2]), 32'h0);
    endtask

    task automatic t_ctl();
        apply(3'd2, 2'd0, 32'h3, 32'h3, 16'hA5C0);
        check_all("R9", 1);
        check("R9", "ctl bits", 32'(flags_o[15:6]), 32'(10'h297));
        apply(3'd6, 2'd2, 32'h1, 32'h0, 16'h5A3F);
        check_all("R9", 1);
    endtask

    task automatic t_idle();
        logic [31:0] r;
        logic [15:0] f;
        apply(3'd0, 2'd0, 32'h10, 32'h20, 16'h0);
        r = result_o; f = flags_o;
        op_i = 3'd2; opa_i = 32'h1; opb_i = 32'h9; flags_i = 16'hFFFF;
        repeat (3) @(negedge clk);
        check("R10", "held result", result_o, r);
        check("R10", "held flags", 32'(flags_o), 32'(f));
        check("R10", "no write", 32'(wr_en_o), 32'h0);
    endtask

    task automatic t_reserved();
        apply(3'd7, 2'd0, 32'h1, 32'h2, 16'h123F);
        check_all("R12", 0);
    endtask

    task automatic t_reset_again();
        apply(3'd2, 2'd0, 32'h0, 32'h1, 16'hFFC0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        t_reset();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_add();
        t_adc_chain();
        t_sub();
        t_sbb_chain();
        t_cmp();
        t_incdec();
        t_size();
        t_ctl();
        t_idle();
        t_reserved();
        t_reset_again();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule